// File: doc/BRIEF.md
# Banked 24-bit Effective Address Generator

This unit forms the 24-bit data address that a 16-bit CPU with a banked memory needs for one operand access. The requester presents a mode code and the operand fields together with the current index registers, stack pointer, direct page base and data bank byte, and pulses `req`. The unit answers with the address and a one-cycle `addrValid` strobe.

Direct-page addresses are built from a full 16-bit page base, so a page that starts near the top of bank 0 reaches into bank 1. When the low byte of that base is not zero, one extra cycle is spent, and `slowPath` is raised together with the strobe. Absolute and indexed addresses take their bank byte from the data bank register. An index carry propagates into that byte. Stack-relative addresses stay in bank 0.

Top module: `bankAddrGen`

## Requirements
- R1: While reset is asserted and in the cycle after it, `addr` is 0, `addrValid` is 0 and `slowPath` is 0.
- R2: Mode code 0 (direct) yields `addr` = page base + `offset[7:0]` as a 17-bit sum, with bits 23..17 zero. Bit 16 is set when the sum passes 0xFFFF.
- R3: Mode code 1 (absolute) yields `addr` = {bank byte, `offset`}.
- R4: Mode codes 2 and 3 (absolute indexed by X or by Y) yield ({bank byte, `offset`} + index) modulo 2^24. A carry out of bit 15 increments the bank byte.
- R5: Mode code 4 (stack relative) yields `addr` = {8'h00, (stack pointer + `offset[7:0]`) modulo 2^16}.
- R6: A request with a direct mode and a page base low byte of 0x00, or with any other mode, raises `addrValid` on the first clock edge after the request edge, with `slowPath` 0.
- R7: A direct-mode request whose page base low byte is non-zero raises `addrValid` one edge later than in R6, with `slowPath` 1 in that cycle.
- R8: `addrValid` is high for one cycle per accepted request. `addr` holds its value until the next result.
- R9: A `req` sampled during the extra cycle of R7 is ignored and produces no result of its own.
- R10: Reserved mode codes 5, 6 and 7 behave exactly as code 1.
- R11: All operands are captured at the request edge. Changes to them during the extra cycle do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, sampled on the rising edge |
| mode | input | 3 | Mode code (see R2 to R5 and R10) |
| offset | input | 16 | Operand offset; direct and stack modes use the low byte |
| idxX | input | 16 | Index register X |
| idxY | input | 16 | Index register Y |
| stackPtr | input | 16 | Stack pointer |
| pageBase | input | 16 | Direct page base |
| bankByte | input | 8 | Data bank byte |
| addr | output | 24 | Generated address |
| addrValid | output | 1 | One-cycle result strobe |
| slowPath | output | 1 | Result took the extra direct-page cycle |

## Verification
If the control state is wrong, the strobe lands one cycle early or late. This is seen at the first port sample after the request edge. A lost or stale operand capture shows up as a wrong address on the strobe cycle of a misaligned direct request. The bench changes every operand in that window to expose it. A broken carry path shows up in the bank byte or in bit 16 only for operand values that cross 0xFFFF. The bench therefore uses values on both sides of each boundary.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
  localparam int WORD_W = 16;
  localparam int BANK_W = 8;
  localparam int PAGE_W = 8;
  localparam int ADDR_W = WORD_W + BANK_W;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_DIR   = 3'd0,
    MODE_ABS   = 3'd1,
    MODE_ABS_X = 3'd2,
    MODE_ABS_Y = 3'd3,
    MODE_STK   = 3'd4,
    MODE_RSV5  = 3'd5,
    MODE_RSV6  = 3'd6,
    MODE_RSV7  = 3'd7
  } addr_mode_t;

  typedef struct packed {
    logic capture;
    logic emit;
    logic useHeld;
    logic slow;
  } gen_ctrl_t;
endpackage

// File: rtl/bank_addr_ctrl.sv
module bank_addr_ctrl
  import bank_addr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      req,
  input  logic      pageMisaligned,
  output gen_ctrl_t ctrl
);
  typedef enum logic {ST_IDLE, ST_EXTRA} st_t;
  st_t state, stateNext;

  always_comb begin
    stateNext    = state;
    ctrl         = '0;
    unique case (state)
      ST_IDLE: begin
        if (req) begin
          if (pageMisaligned) begin
            ctrl.capture = 1'b1;
            stateNext    = ST_EXTRA;
          end else begin
            ctrl.emit = 1'b1;
          end
        end
      end
      ST_EXTRA: begin
        ctrl.emit    = 1'b1;
        ctrl.useHeld = 1'b1;
        ctrl.slow    = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R7: the extra cycle lasts exactly one cycle
  p_extra_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXTRA) |=> (state == ST_IDLE));
  // R9: requests seen while busy start nothing
  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXTRA && req) |=> (state == ST_IDLE && !ctrl.useHeld));
  // R6: a fast request emits in the same cycle and never captures
  p_fast_emit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && req && !pageMisaligned) |-> (ctrl.emit && !ctrl.capture));
endmodule

// File: rtl/bank_addr_dp.sv
module bank_addr_dp
  import bank_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  gen_ctrl_t         ctrl,
  input  logic [MODE_W-1:0] modeIn,
  input  logic [WORD_W-1:0] offIn,
  input  logic [WORD_W-1:0] xIn,
  input  logic [WORD_W-1:0] yIn,
  input  logic [WORD_W-1:0] spIn,
  input  logic [WORD_W-1:0] dprIn,
  input  logic [BANK_W-1:0] dtIn,
  output logic              pageMisaligned,
  output logic [ADDR_W-1:0] addrOut,
  output logic              validOut,
  output logic              slowOut
);
  localparam int DIR_W = WORD_W + 1;

  addr_mode_t        heldMode, srcMode;
  logic [WORD_W-1:0] heldOff, heldX, heldY, heldSp, heldDpr;
  logic [BANK_W-1:0] heldDt;
  logic [WORD_W-1:0] srcOff, srcX, srcY, srcSp, srcDpr;
  logic [BANK_W-1:0] srcDt;
  logic [ADDR_W-1:0] absBase, nextAddr;
  logic [DIR_W-1:0]  dirSum;
  logic [WORD_W-1:0] stkSum;

  assign pageMisaligned = (addr_mode_t'(modeIn) == MODE_DIR) && (dprIn[PAGE_W-1:0] != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldMode <= MODE_DIR;
      heldOff  <= '0; heldX <= '0; heldY <= '0;
      heldSp   <= '0; heldDpr <= '0; heldDt <= '0;
    end else if (ctrl.capture) begin
      heldMode <= addr_mode_t'(modeIn);
      heldOff  <= offIn; heldX <= xIn; heldY <= yIn;
      heldSp   <= spIn;  heldDpr <= dprIn; heldDt <= dtIn;
    end
  end

  always_comb begin
    if (ctrl.useHeld) begin
      srcMode = heldMode; srcOff = heldOff; srcX = heldX; srcY = heldY;
      srcSp = heldSp; srcDpr = heldDpr; srcDt = heldDt;
    end else begin
      srcMode = addr_mode_t'(modeIn); srcOff = offIn; srcX = xIn; srcY = yIn;
      srcSp = spIn; srcDpr = dprIn; srcDt = dtIn;
    end
  end

  always_comb begin
    absBase = {srcDt, srcOff};
    dirSum  = {1'b0, srcDpr} + {{(DIR_W-PAGE_W){1'b0}}, srcOff[PAGE_W-1:0]};
    stkSum  = srcSp + {{(WORD_W-PAGE_W){1'b0}}, srcOff[PAGE_W-1:0]};
    unique case (srcMode)
      MODE_DIR:   nextAddr = {{(ADDR_W-DIR_W){1'b0}}, dirSum};
      MODE_ABS_X: nextAddr = absBase + {{BANK_W{1'b0}}, srcX};
      MODE_ABS_Y: nextAddr = absBase + {{BANK_W{1'b0}}, srcY};
      MODE_STK:   nextAddr = {{BANK_W{1'b0}}, stkSum};
      default:    nextAddr = absBase;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrOut  <= '0;
      validOut <= 1'b0;
      slowOut  <= 1'b0;
    end else begin
      validOut <= ctrl.emit;
      slowOut  <= ctrl.emit & ctrl.slow;
      if (ctrl.emit) addrOut <= nextAddr;
    end
  end

  // R6: every emit becomes a strobe on the next cycle
  p_emit_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.emit |=> validOut);
  // R7: the slow flag never appears without a strobe
  p_slow_with_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    slowOut |-> validOut);
  // R2: direct results stay inside banks 0 and 1
  p_dir_bank_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.emit && srcMode == MODE_DIR) |=> (addrOut[ADDR_W-1:DIR_W] == '0));
  // R8: the address holds between results
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.emit |=> $stable(addrOut));
  // R5: stack results stay in bank 0
  p_stk_bank_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.emit && srcMode == MODE_STK) |=> (addrOut[ADDR_W-1:WORD_W] == '0));
endmodule

// File: rtl/bankAddrGen.sv
module bankAddrGen
  import bank_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic [MODE_W-1:0] mode,
  input  logic [WORD_W-1:0] offset,
  input  logic [WORD_W-1:0] idxX,
  input  logic [WORD_W-1:0] idxY,
  input  logic [WORD_W-1:0] stackPtr,
  input  logic [WORD_W-1:0] pageBase,
  input  logic [BANK_W-1:0] bankByte,
  output logic [ADDR_W-1:0] addr,
  output logic              addrValid,
  output logic              slowPath
);
  gen_ctrl_t ctrl;
  logic      pageMisaligned;

  bank_addr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .req(req),
    .pageMisaligned(pageMisaligned), .ctrl(ctrl)
  );

  bank_addr_dp uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .modeIn(mode), .offIn(offset), .xIn(idxX), .yIn(idxY),
    .spIn(stackPtr), .dprIn(pageBase), .dtIn(bankByte),
    .pageMisaligned(pageMisaligned),
    .addrOut(addr), .validOut(addrValid), .slowOut(slowPath)
  );
endmodule

// File: tb/bankAddrGen_test.sv
module bankAddrGen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] offset = '0, idxX = '0, idxY = '0, stackPtr = '0, pageBase = '0;
  logic [7:0]  bankByte = '0;
  logic [23:0] addr;
  logic        addrValid, slowPath;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bankAddrGen uut (
    .clk(clk), .rstN(rstN), .req(req), .mode(mode), .offset(offset),
    .idxX(idxX), .idxY(idxY), .stackPtr(stackPtr), .pageBase(pageBase),
    .bankByte(bankByte), .addr(addr), .addrValid(addrValid), .slowPath(slowPath)
  );

  function automatic logic [23:0] model(input logic [2:0] m, input logic [15:0] o,
      input logic [15:0] x, input logic [15:0] y, input logic [15:0] sp,
      input logic [15:0] dp, input logic [7:0] dt);
    int unsigned base;
    base = (int'(dt) << 16) | int'(o);
    case (m)
      3'd0: return 24'(int'(dp) + int'(o[7:0]));
      3'd2: return 24'((base + int'(x)) & 32'hFF_FFFF);
      3'd3: return 24'((base + int'(y)) & 32'hFF_FFFF);
      3'd4: return {8'h00, 16'((int'(sp) + int'(o[7:0])) & 32'hFFFF)};
      default: return 24'(base);
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] m, input logic [15:0] o, input logic [15:0] x,
      input logic [15:0] y, input logic [15:0] sp, input logic [15:0] dp, input logic [7:0] dt);
    mode = m; offset = o; idxX = x; idxY = y; stackPtr = sp; pageBase = dp; bankByte = dt;
  endtask

  // one request; checks strobe timing and the address
  task automatic oneReq(input string tag, input logic [2:0] m, input logic [15:0] o,
      input logic [15:0] x, input logic [15:0] y, input logic [15:0] sp,
      input logic [15:0] dp, input logic [7:0] dt, input bit expSlow);
    logic [23:0] exp;
    exp = model(m, o, x, y, sp, dp, dt);
    @(negedge clk);
    drive(m, o, x, y, sp, dp, dt);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (expSlow) begin
      check({tag, " R7 no early strobe"}, {31'b0, addrValid}, 32'd0);
      @(negedge clk);
    end
    check({tag, " strobe"}, {31'b0, addrValid}, 32'd1);
    check({tag, " slow flag"}, {31'b0, slowPath}, {31'b0, expSlow});
    check({tag, " addr"}, {8'b0, addr}, {8'b0, exp});
    @(negedge clk);
    check({tag, " R8 single pulse"}, {31'b0, addrValid}, 32'd0);
    check({tag, " R8 hold"}, {8'b0, addr}, {8'b0, exp});
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 addr", {8'b0, addr}, 32'd0);
    check("R1 valid", {31'b0, addrValid}, 32'd0);
    check("R1 slow", {31'b0, slowPath}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", {31'b0, addrValid}, 32'd0);
  endtask

  task automatic testDirect();
    oneReq("R2 R6 aligned", 3'd0, 16'h1234, 0, 0, 0, 16'h0300, 8'h55, 1'b0);
    oneReq("R2 R6 top of bank0", 3'd0, 16'h00FF, 0, 0, 0, 16'hFF00, 8'h55, 1'b0);
    oneReq("R2 R7 cross into bank1", 3'd0, 16'h00FF, 0, 0, 0, 16'hFF01, 8'h55, 1'b1);
    oneReq("R2 R7 misaligned no cross", 3'd0, 16'h0010, 0, 0, 0, 16'h2001, 8'h55, 1'b1);
    check("R2 bank1 value", {8'b0, model(3'd0, 16'h00FF, 0, 0, 0, 16'hFFFF, 8'h00)}, 32'h0001_00FE);
  endtask

  task automatic testAbsolute();
    oneReq("R3 absolute", 3'd1, 16'hBEEF, 16'h1111, 16'h2222, 0, 16'h0001, 8'h7A, 1'b0);
    oneReq("R4 X no carry", 3'd2, 16'h1000, 16'h0234, 0, 0, 0, 8'h12, 1'b0);
    oneReq("R4 X bank carry", 3'd2, 16'hFFF0, 16'h0020, 0, 0, 0, 8'h12, 1'b0);
    oneReq("R4 Y bank carry", 3'd3, 16'h8000, 16'h0005, 16'h9000, 0, 0, 8'h40, 1'b0);
    oneReq("R4 Y wrap 24 bits", 3'd3, 16'hFFFF, 0, 16'h0002, 0, 0, 8'hFF, 1'b0);
  endtask

  task automatic testStack();
    oneReq("R5 stack", 3'd4, 16'hAB10, 0, 0, 16'h01F0, 16'h0005, 8'h33, 1'b0);
    oneReq("R5 stack wrap", 3'd4, 16'h0020, 0, 0, 16'hFFF0, 16'h0005, 8'h33, 1'b0);
  endtask

  task automatic testReserved();
    for (int c = 5; c < 8; c++)
      oneReq("R10 reserved as absolute", 3'(c), 16'h4321, 16'h0F00, 16'h0E00, 16'h1000,
             16'h0007, 8'hC3, 1'b0);
  endtask

  // second request and operand changes during the extra cycle
  task automatic testBusy();
    logic [23:0] exp;
    int pulses = 0;
    exp = 24'(32'h0000_4101 + 32'h42);
    @(negedge clk);
    drive(3'd0, 16'h0042, 0, 0, 0, 16'h4101, 8'h09);
    req = 1'b1;
    @(negedge clk);
    drive(3'd1, 16'h7777, 16'h1, 16'h2, 16'h3, 16'h0000, 8'hEE);
    check("R7 R9 still waiting", {31'b0, addrValid}, 32'd0);
    @(negedge clk);
    req = 1'b0;
    check("R7 late strobe", {31'b0, addrValid}, 32'd1);
    check("R7 slow flag", {31'b0, slowPath}, 32'd1);
    check("R11 captured operands", {8'b0, addr}, {8'b0, exp});
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (addrValid) pulses++;
    end
    check("R9 busy request dropped", pulses, 0);
    check("R9 addr unchanged", {8'b0, addr}, {8'b0, exp});
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    drive(3'd1, 16'h0101, 0, 0, 0, 0, 8'h01);
    req = 1'b1;
    @(negedge clk);
    drive(3'd4, 16'h0003, 0, 0, 16'h0200, 0, 8'h01);
    check("R6 R8 first of pair", {8'b0, addr}, 32'h0001_0101);
    check("R6 first strobe", {31'b0, addrValid}, 32'd1);
    @(negedge clk);
    req = 1'b0;
    check("R6 R8 second of pair", {8'b0, addr}, 32'h0000_0203);
    check("R6 second strobe", {31'b0, addrValid}, 32'd1);
    @(negedge clk);
    check("R8 strobe ends", {31'b0, addrValid}, 32'd0);
  endtask

  initial begin
    testReset();
    testDirect();
    testAbsolute();
    testStack();
    testReserved();
    testBusy();
    testBackToBack();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule